// File: doc/BRIEF.md
# Serial Code-Phase Search Controller

This block finds the code phase of a known spreading code in a baseband chip stream whose carrier frequency and phase are already removed. Each enabled chip, it multiplies the signed incoming sample by a local replica bit mapped to ±1. It adds the product to a running sum that covers exactly one code period. When a period ends, the sum is dumped to an output and checked against a detection level.

A weak dump means the replica is misaligned. The controller then asks the code generator, through a one-cycle slip pulse, to delay the replica by half a chip, and it advances its own record of the phase being tested. A dump whose magnitude reaches the detection level, positive or negative, ends the search. The status output then reads "equal" and stays there until reset, so a tracking loop can take over. Correlation and dumps continue after the lock, so the tracker keeps receiving period sums.

Top module: `pn_acq_ctrl`

## Requirements
- R1: The sample is a SAMPLE_W-bit two's complement value (default 3). A replica bit of 0 adds the sample to the running sum and a replica bit of 1 subtracts it, at full precision, including the most negative sample.
- R2: Every CODE_LEN enabled chips (default 1023), corr_sum_o takes the sum of that period in the cycle after the last chip, and dump_o is high for exactly that one cycle. The next period starts again from zero.
- R3: A cycle with chip_en_i low neither adds its sample nor counts toward the period.
- R4: While searching, a dump whose magnitude is below DETECT_LEVEL (default 1022) makes slip_o high for one cycle, in the cycle after dump_o. In that same cycle phase_o has advanced by one. At no other time does slip_o rise or phase_o move.
- R5: A dump whose magnitude is at least DETECT_LEVEL, of either sign, sets locked_o to 1 (status "equal") in the cycle after dump_o, with no slip.
- R6: Once set, locked_o stays 1 until reset. After that, dumps continue but slip_o stays 0 and phase_o holds.
- R7: phase_o counts half chips and wraps from 2*CODE_LEN-1 back to 0.
- R8: rst_n is an asynchronous active-low reset. While it is low, corr_sum_o, dump_o, slip_o, locked_o (status "less") and phase_o are all 0, and any partial sum is discarded. The search starts one cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Marks a cycle that carries a chip |
| sample_i | input | SAMPLE_W | Signed incoming sample |
| replica_i | input | 1 | Local replica code bit (0 means +1, 1 means -1) |
| corr_sum_o | output | SUM_W | Signed sum of the last completed period |
| dump_o | output | 1 | One-cycle pulse when corr_sum_o is updated |
| slip_o | output | 1 | One-cycle request to delay the replica by half a chip |
| locked_o | output | 1 | Status: 0 = less (searching), 1 = equal (acquired) |
| phase_o | output | PH_W | Half-chip phase offset currently tested |

## Verification
The bench goes after these corner cases:

- **Exact threshold.** It sends one period whose sum falls one short of the level and one whose sum equals it, with the second one negative. A comparator that used the wrong inequality, or ignored the sign, would slip on the hit or lock on the miss.
- **Skipped chips.** Idle cycles carrying junk samples are placed between chips. A design that accumulated them, or counted them, would dump a wrong sum or dump early.
- **Most negative sample.** An all-negative sample run is sent against a replica bit of 1. A design that negated the sample in its own width would overflow and produce a small or negative sum.
- **Phase wrap.** A long run of weak periods shows whether phase_o wraps at the right count.
- **Mid-period reset.** A reset asserted between clock edges shows whether partial state is discarded at once.

// File: rtl/pn_acq_pkg.sv
package pn_acq_pkg;
  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_HUNT = 2'd1,
    SRCH_LOCK = 2'd2
  } srch_state_e;
endpackage

// File: rtl/pn_acq_corr.sv
module pn_acq_corr #(
  parameter int SAMPLE_W = 3,
  parameter int CODE_LEN = 1023,
  parameter int SUM_W    = 13,
  parameter int CNT_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic                    chip_en_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic                    replica_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic                    dump_o
);
  logic signed [SUM_W-1:0] acc_q, acc_d;
  logic signed [SUM_W-1:0] sum_q, sum_d;
  logic signed [SUM_W-1:0] smp_ext, prod, total;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    dump_q, dump_d;
  logic                    last_chip;

  assign smp_ext   = {{(SUM_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
  assign prod      = replica_i ? -smp_ext : smp_ext;
  assign total     = acc_q + prod;
  assign last_chip = (cnt_q == CNT_W'(CODE_LEN - 1));

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    sum_d  = sum_q;
    dump_d = 1'b0;
    if (!run_i) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (chip_en_i) begin
      if (last_chip) begin
        sum_d  = total;
        dump_d = 1'b1;
        acc_d  = '0;
        cnt_d  = '0;
      end else begin
        acc_d = total;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
      dump_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      sum_q  <= sum_d;
      dump_q <= dump_d;
    end
  end

  assign sum_o  = sum_q;
  assign dump_o = dump_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CODE_LEN)); // R2
  AST_DUMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |=> !dump_q); // R2
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !chip_en_i) |=> ($stable(cnt_q) && $stable(acc_q))); // R3
  AST_SUM_ONLY_ON_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_q |-> $stable(sum_q)); // R2
endmodule

// File: rtl/pn_acq_srch.sv
module pn_acq_srch
  import pn_acq_pkg::*;
#(
  parameter int SUM_W        = 13,
  parameter int DETECT_LEVEL = 1022,
  parameter int PH_BINS      = 2046,
  parameter int PH_W         = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dump_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic                    run_o,
  output logic                    slip_o,
  output logic                    locked_o,
  output logic [PH_W-1:0]         phase_o
);
  srch_state_e           state_q, state_d;
  logic                  slip_q, slip_d;
  logic [PH_W-1:0]       phase_q, phase_d;
  logic signed [SUM_W:0] sum_ext, mag;
  logic                  hit;

  assign sum_ext = {sum_i[SUM_W-1], sum_i};
  assign mag     = sum_ext[SUM_W] ? -sum_ext : sum_ext;
  assign hit     = (mag >= $signed((SUM_W+1)'(DETECT_LEVEL)));

  always_comb begin
    state_d = state_q;
    slip_d  = 1'b0;
    phase_d = phase_q;
    case (state_q)
      SRCH_IDLE: state_d = SRCH_HUNT;
      SRCH_HUNT: begin
        if (dump_i) begin
          if (hit) begin
            state_d = SRCH_LOCK;
          end else begin
            slip_d  = 1'b1;
            phase_d = (phase_q == PH_W'(PH_BINS - 1)) ? '0 : phase_q + 1'b1;
          end
        end
      end
      SRCH_LOCK: state_d = SRCH_LOCK;
      default:   state_d = SRCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRCH_IDLE;
      slip_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      state_q <= state_d;
      slip_q  <= slip_d;
      phase_q <= phase_d;
    end
  end

  assign run_o    = (state_q != SRCH_IDLE);
  assign slip_o   = slip_q;
  assign locked_o = (state_q == SRCH_LOCK);
  assign phase_o  = phase_q;

  AST_SLIP_AFTER_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |-> $past(dump_i)); // R4
  AST_SLIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |=> !slip_o); // R4
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_o |-> $stable(phase_o)); // R4
  AST_NO_SLIP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> !slip_o); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o); // R6
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o < PH_W'(PH_BINS)); // R7
endmodule

// File: rtl/pn_acq_ctrl.sv
module pn_acq_ctrl #(
  parameter int SAMPLE_W     = 3,
  parameter int CODE_LEN     = 1023,
  parameter int DETECT_LEVEL = 1022,
  localparam int SUM_W   = $clog2(CODE_LEN * (2 ** (SAMPLE_W - 1)) + 1) + 1,
  localparam int CNT_W   = $clog2(CODE_LEN),
  localparam int PH_BINS = 2 * CODE_LEN,
  localparam int PH_W    = $clog2(PH_BINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chip_en_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic                    replica_i,
  output logic signed [SUM_W-1:0] corr_sum_o,
  output logic                    dump_o,
  output logic                    slip_o,
  output logic                    locked_o,
  output logic [PH_W-1:0]         phase_o
);
  logic run;

  pn_acq_corr #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_LEN (CODE_LEN),
    .SUM_W    (SUM_W),
    .CNT_W    (CNT_W)
  ) u_corr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .chip_en_i (chip_en_i),
    .sample_i  (sample_i),
    .replica_i (replica_i),
    .sum_o     (corr_sum_o),
    .dump_o    (dump_o)
  );

  pn_acq_srch #(
    .SUM_W        (SUM_W),
    .DETECT_LEVEL (DETECT_LEVEL),
    .PH_BINS      (PH_BINS),
    .PH_W         (PH_W)
  ) u_srch (
    .clk      (clk),
    .rst_n    (rst_n),
    .dump_i   (dump_o),
    .sum_i    (corr_sum_o),
    .run_o    (run),
    .slip_o   (slip_o),
    .locked_o (locked_o),
    .phase_o  (phase_o)
  );

  AST_DUMP_THEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(dump_o)); // R5
endmodule

// File: tb/pn_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pn_acq_ctrl_tb_top;
  localparam int SW    = 3;
  localparam int CLEN  = 31;
  localparam int LEVEL = 30;
  localparam int SUMW  = $clog2(CLEN * (2 ** (SW - 1)) + 1) + 1;
  localparam int BINS  = 2 * CLEN;
  localparam int PHW   = $clog2(BINS);

  typedef struct {
    int sum;
    bit slip;
    bit locked;
    int phase;
  } exp_t;

  logic                   clk;
  logic                   rst_n;
  logic                   chip_en_i;
  logic [SW-1:0]          sample_i;
  logic                   replica_i;
  logic signed [SUMW-1:0] corr_sum_o;
  logic                   dump_o, slip_o, locked_o;
  logic [PHW-1:0]         phase_o;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t q[$];
  bit   m_locked;
  int   m_phase;
  logic [15:0] lfsr = 16'hACE1;

  pn_acq_ctrl #(.SAMPLE_W(SW), .CODE_LEN(CLEN), .DETECT_LEVEL(LEVEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en_i), .sample_i(sample_i),
    .replica_i(replica_i), .corr_sum_o(corr_sum_o), .dump_o(dump_o),
    .slip_o(slip_o), .locked_o(locked_o), .phase_o(phase_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int s, input bit r, input bit en);
    @(negedge clk);
    chip_en_i = en;
    sample_i  = SW'(s);
    replica_i = r;
  endtask

  function automatic int next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[7:0]);
  endfunction

  // kind 0: weak alternating, 1: pseudo-random, 2: cnt ones with polarity pol, 3: all -4 against replica 1
  task automatic run_period(input int kind, input int cnt, input bit pol, input bit gaps);
    int   s[CLEN];
    bit   r[CLEN];
    int   tot = 0;
    exp_t e;
    for (int k = 0; k < CLEN; k++) begin
      case (kind)
        0: begin s[k] = (k % 2 == 1) ? 1 : -1; r[k] = 1'b0; end
        1: begin s[k] = (next_rand() % 8) - 4; r[k] = next_rand()[0]; end
        2: begin s[k] = (k < cnt) ? 1 : 0; r[k] = pol; end
        default: begin s[k] = -4; r[k] = 1'b1; end
      endcase
      tot += r[k] ? -s[k] : s[k];
    end
    e.sum = tot;
    if (m_locked) begin
      e.slip = 1'b0;
    end else if (tot >= LEVEL || -tot >= LEVEL) begin
      m_locked = 1'b1;
      e.slip   = 1'b0;
    end else begin
      e.slip  = 1'b1;
      m_phase = (m_phase == BINS - 1) ? 0 : m_phase + 1;
    end
    e.locked = m_locked;
    e.phase  = m_phase;
    q.push_back(e);
    for (int k = 0; k < CLEN; k++) begin
      drive(s[k], r[k], 1'b1);
      if (gaps) drive(3, 1'b1, 1'b0);
    end
  endtask

  task automatic wait_drain();
    drive(0, 1'b0, 1'b0);
    for (int i = 0; i < 10 && q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard at each dump
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && dump_o === 1'b1) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected dump", 1, 0);
        end else begin
          e = q.pop_front();
          check(int'(corr_sum_o) == e.sum, "R1/R2 period sum", int'(corr_sum_o), e.sum);
          @(negedge clk);
          check(slip_o == e.slip, "R4/R6 slip after dump", int'(slip_o), int'(e.slip));
          check(locked_o == e.locked, "R5/R6 status after dump", int'(locked_o), int'(e.locked));
          check(int'(phase_o) == e.phase, "R4/R7 phase", int'(phase_o), e.phase);
          check(dump_o == 1'b0, "R2 dump single cycle", int'(dump_o), 0);
        end
      end
    end
  end

  task automatic check_reset_outputs(input string tag);
    check(corr_sum_o == '0, {tag, " sum"}, int'(corr_sum_o), 0);
    check(dump_o == 1'b0 && slip_o == 1'b0, {tag, " pulses"}, int'({dump_o, slip_o}), 0);
    check(locked_o == 1'b0, {tag, " status less"}, int'(locked_o), 0);
    check(phase_o == '0, {tag, " phase"}, int'(phase_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; chip_en_i = 1'b0; sample_i = '0; replica_i = 1'b0;
    m_locked = 1'b0; m_phase = 0;
    repeat (3) @(negedge clk);
    check_reset_outputs("R8 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_period(1, 0, 1'b0, 1'b0);   // R1 random, R4 slip
    run_period(1, 0, 1'b0, 1'b1);   // R3 idle cycles with junk
    run_period(2, 29, 1'b0, 1'b0);  // R4 one below level: slip
    run_period(2, 30, 1'b1, 1'b0);  // R5 negative sum at level: lock
    run_period(1, 0, 1'b0, 1'b1);   // R6 locked: no slip, phase held
    run_period(2, 31, 1'b0, 1'b0);  // R6 strong again: still no slip
    wait_drain();
    check(q.size() == 0, "R2 all dumps seen", q.size(), 0);

    // R8: partial period, then asynchronous reset between edges
    for (int k = 0; k < 10; k++) drive(3, 1'b0, 1'b1);
    #3 rst_n = 1'b0;
    #2 check_reset_outputs("R8 async reset");
    m_locked = 1'b0; m_phase = 0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 1'b0, 1'b0);
    drive(0, 1'b0, 1'b0);

    for (int p = 0; p < BINS + 1; p++) run_period(0, 0, 1'b0, 1'b0); // R7 wrap
    run_period(3, 0, 1'b0, 1'b0);   // R1 most negative sample, lock
    wait_drain();
    check(q.size() == 0, "R2 all dumps seen", q.size(), 0);
    check(int'(phase_o) == 1, "R7 phase after wrap", int'(phase_o), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule